// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Transmitter

This block sends bytes on one serial line using an asynchronous frame that carries an extra flag bit after the data. The flag lets a receiver tell an address (ID) frame from a data frame. Software, or an external DMA-style writer, places a byte in a holding register. The byte is committed when the ready flag is cleared. At the start of a frame the transmitter copies the holding register into a shift register and sets the ready flag again. The next byte can therefore be queued while the current frame is still on the line, and consecutive frames leave no gap between them.

A finished flag reports that the line has gone idle with nothing left to send. A request output asks the DMA writer for the next byte. A DMA write stores the byte and clears the ready flag in a single step. When the transmitter is disabled, the line and its output enable follow two general-purpose port bits. Software can then hold the line low to send a break. The bit time comes from a programmable divider.

Top module: `mptx_uart_tx`

## Requirements
- R1: After reset the status register reads ready=1 and done=1 with flag bit 0, the control register reads 0, and `txd`/`txd_oe` follow `port_dat`/`port_dir`.
- R2: Register map. Address 0 is the holding register. Address 1 is control, with bit 0 as enable. Address 2 is status: bit 0 ready, bit 1 done, bit 2 flag value. Address 3 is the divisor. A frame on `txd` is a 0 start bit, then 8 data bits least significant first, then the flag bit, then a 1 stop bit. An enabled idle line is 1.
- R3: Every bit lasts divisor+1 clock cycles.
- R4: A bus write to status with bit 0 = 0 while ready=1 clears ready and commits the held byte. The frame's start bit appears on the next cycle. Writing 1 to bit 0 has no effect.
- R5: The flag bit sent in a frame is the value of status bit 2 when that frame starts.
- R6: Ready returns to 1 in the cycle the start bit appears. A byte committed during a frame starts right after that frame's stop bit, with no idle bit in between.
- R7: Done goes to 0 on commit. It goes to 1 when a stop bit ends with ready=1. Bus writes to status bit 1 have no effect.
- R8: `txi` is high exactly when enable=1 and ready=1. A `dma_wr` pulse stores `dma_wdata` and commits it like R4.
- R9: With enable=0, `txd`=`port_dat` and `txd_oe`=`port_dir`. With enable=1, `txd_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| dma_wr | input | 1 | DMA write to holding register with auto-commit |
| dma_wdata | input | 8 | DMA write data |
| port_dat | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | General-purpose port direction bit (1 = drive) |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Serial line output enable |
| txi | output | 1 | Transmit-empty request |

## Verification
On every cycle, the assertions check several invariants. A commit clears ready, and a load sets it again. Done never stands while ready is low. Every frame begins low and ends high, and the divider reloads at each frame start. Only the bench's scenarios can show the rest: the full bit order with the flag value, the exact bit length for a given divisor, gap-free back-to-back frames, the DMA auto-commit, writes that must be ignored, and the port fallback that produces a break.

// File: rtl/mptx_pkg.sv
// Shared register addresses and status bit positions for the serial transmitter.
package mptx_pkg;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int S_READY = 0;
    localparam int S_DONE  = 1;
    localparam int S_FLAG  = 2;
endpackage

// File: rtl/mptx_baud.sv
// Bit-time divider. Emits tick once per DIV+1 cycles while run is high.
// Assumes restart is asserted in the cycle a frame is loaded, so that the
// first bit of every frame gets a full period.
module mptx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count down and reload on restart, on idle, or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run || cnt == '0)
            cnt <= div;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);

    a_r3_reload_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == $past(div)));
endmodule

// File: rtl/mptx_shift.sv
// Frame engine: loads start, data, flag and stop bits into a shift register
// and steps one bit per tick. Assumes pending means a committed byte waits in
// the holding register. Disabling aborts the frame in progress.
module mptx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pending,
    input  logic [DATA_W-1:0] hold,
    input  logic              flag,
    input  logic              tick,
    output logic              load,
    output logic              done,
    output logic              busy,
    output logic              line
);
    localparam int FRM = DATA_W + 3;
    localparam int CW  = $clog2(FRM);

    logic [FRM-1:0] sh;
    logic [CW-1:0]  left;
    logic           last;

    // End of the stop bit, and the frame start or chaining decision.
    always_comb begin
        last = busy && tick && (left == '0);
        load = en && pending && (!busy || last);
        done = last && !pending;
    end

    // Shift register, remaining bit count and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (!en) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= {1'b1, flag, hold, 1'b0};
            left <= CW'(FRM - 1);
        end else if (busy && tick) begin
            if (left == '0) begin
                busy <= 1'b0;
            end else begin
                sh   <= {1'b1, sh[FRM-1:1]};
                left <= left - 1'b1;
            end
        end
    end

    assign line = busy ? sh[0] : 1'b1;

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (line == 1'b0));
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left == '0) |-> (line == 1'b1));
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line == 1'b1));
endmodule

// File: rtl/mptx_regs.sv
// Register file and handshake flags. Assumes load only occurs while ready=0
// and that a commit is only honoured while ready=1, so the two never collide.
module mptx_regs
    import mptx_pkg::*;
#(
    parameter int               DATA_W  = 8,
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              load,
    input  logic              done,
    output logic [DATA_W-1:0] hold,
    output logic              en,
    output logic              flag,
    output logic [DIV_W-1:0]  div,
    output logic              ready,
    output logic              fin
);
    logic wr_stat, commit;

    // Decode a commit from software or the DMA path.
    always_comb begin
        wr_stat = bus_wr && (bus_addr == A_STAT);
        commit  = ready && (dma_wr || (wr_stat && !bus_wdata[S_READY]));
    end

    // Holding register: DMA write wins over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (dma_wr)
            hold <= dma_wdata;
        else if (bus_wr && bus_addr == A_DATA)
            hold <= bus_wdata;
    end

    // Control, flag value and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            flag <= 1'b0;
            div  <= DIV_RST;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) en   <= bus_wdata[0];
            if (bus_addr == A_STAT) flag <= bus_wdata[S_FLAG];
            if (bus_addr == A_DIV)  div  <= bus_wdata[DIV_W-1:0];
        end
    end

    // Ready and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b1;
            fin   <= 1'b1;
        end else begin
            if (load)        ready <= 1'b1;
            else if (commit) ready <= 1'b0;
            if (commit)      fin   <= 1'b0;
            else if (done)   fin   <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            A_DATA: bus_rdata = hold;
            A_CTRL: bus_rdata[0] = en;
            A_STAT: begin
                bus_rdata[S_READY] = ready;
                bus_rdata[S_DONE]  = fin;
                bus_rdata[S_FLAG]  = flag;
            end
            default: bus_rdata[DIV_W-1:0] = div;
        endcase
    end

    a_r4_commit_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !ready);
    a_r6_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ready);
    a_r7_done_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ready);
    a_r7_done_sets_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !commit) |=> fin);
endmodule

// File: rtl/mptx_uart_tx.sv
// Top level: the register file, divider and frame engine, plus the pin
// fallback to port control when the transmitter is disabled.
module mptx_uart_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              port_dat,
    input  logic              port_dir,
    output logic              txd,
    output logic              txd_oe,
    output logic              txi
);
    logic [DATA_W-1:0] hold;
    logic [DIV_W-1:0]  div;
    logic en, flag, ready, fin, load, done, busy, line, tick;

    mptx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .load(load), .done(done),
        .hold(hold), .en(en), .flag(flag), .div(div),
        .ready(ready), .fin(fin)
    );

    mptx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
        .div(div), .tick(tick)
    );

    mptx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(en), .pending(!ready),
        .hold(hold), .flag(flag), .tick(tick),
        .load(load), .done(done), .busy(busy), .line(line)
    );

    // Pin ownership and request output.
    always_comb begin
        txd    = en ? line : port_dat;
        txd_oe = en ? 1'b1 : port_dir;
        txi    = en && ready;
    end
endmodule

// File: tb/mptx_uart_tx_bench.sv
module mptx_uart_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [1:0] bus_raddr = 2;
    logic [7:0] bus_rdata;
    logic       dma_wr = 0;
    logic [7:0] dma_wdata = 0;
    logic       port_dat = 1;
    logic       port_dir = 0;
    logic       txd, txd_oe, txi;

    int n_run = 0;
    int n_fail = 0;
    int divv = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    mptx_uart_tx u_mptx_uart_tx (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .port_dat(port_dat), .port_dir(port_dir),
        .txd(txd), .txd_oe(txd_oe), .txi(txi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_raddr = a;
        #1 v = bus_rdata;
    endtask

    // Wait for a start bit, then sample n bits at mid-bit.
    task automatic rx(input int n, output logic [31:0] bits);
        int guard = 0;
        bits = '0;
        while (txd !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        if (txd !== 1'b0) check("R2 start bit seen", 0, 1);
        repeat ((divv + 1) / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bits[i] = txd;
            if (i != n - 1) repeat (divv + 1) @(negedge clk);
        end
    endtask

    function automatic logic [10:0] frame(input logic [7:0] d, input logic f);
        return {1'b1, f, d, 1'b0};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd(2, v); check("R1 status after reset", v, 8'h03);
        rd(1, v); check("R1 control after reset", v, 8'h00);
        port_dat = 0; port_dir = 1; #1;
        check("R1 txd follows port", {txd, txd_oe}, 2'b01);
        port_dat = 1; port_dir = 0; #1;
        check("R1 oe follows port", {txd, txd_oe}, 2'b10);
    endtask

    task automatic t_frame(input logic [7:0] d, input logic f);
        logic [7:0] v;
        logic [31:0] bits;
        wr(2, {5'b0, f, 2'b11});
        wr(0, d);
        wr(2, {5'b0, f, 2'b10});
        rd(2, v); check("R7 done cleared on commit", v[1:0], 2'b00);
        @(negedge clk);
        rd(2, v); check("R6 ready back at frame start", v[0], 1);
        check("R4 start bit on next cycle", txd, 0);
        rx(11, bits);
        check("R2 R5 frame bits", bits[10:0], frame(d, f));
        rd(2, v); check("R7 done low during stop bit", v[1], 0);
        repeat (2) @(negedge clk);
        rd(2, v); check("R7 done after stop bit", v[1], 1);
        check("R2 idle high", txd, 1);
    endtask

    task automatic t_period();
        int lows = 0;
        divv = 5;
        wr(3, 8'd5);
        wr(0, 8'h01);
        wr(2, 8'h00);
        @(negedge clk);
        while (txd === 1'b0 && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        check("R3 start bit length for divisor 5", lows, 6);
        repeat (70) @(negedge clk);
        divv = 3;
        wr(3, 8'd3);
    endtask

    task automatic t_back_to_back();
        logic [31:0] bits;
        logic [7:0] v;
        wr(0, 8'h3C);
        wr(2, 8'h04);
        fork
            rx(22, bits);
            begin
                @(negedge clk);
                wr(0, 8'hC3);
                wr(2, 8'h00);
            end
        join
        check("R6 first chained frame", bits[10:0], frame(8'h3C, 1'b1));
        check("R6 R5 second frame no gap", bits[21:11], frame(8'hC3, 1'b0));
        rd(2, v); check("R7 done low until last stop ends", v[1], 0);
        repeat (2) @(negedge clk);
        rd(2, v); check("R7 done after chained frames", v[1], 1);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        int lows = 0;
        wr(2, 8'h01);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R4 writing 1 to ready starts nothing", lows, 0);
        rd(2, v); check("R7 done ignores write of 0", v[2:0], 3'b011);
    endtask

    task automatic t_dma();
        logic [7:0] v;
        logic [31:0] bits;
        check("R8 txi high when enabled and ready", txi, 1);
        @(negedge clk);
        dma_wr = 1; dma_wdata = 8'h96;
        @(negedge clk);
        dma_wr = 0;
        rd(2, v); check("R8 DMA write clears ready", v[0], 0);
        check("R8 txi low after DMA write", txi, 0);
        rx(11, bits);
        check("R8 DMA byte sent", bits[10:0], frame(8'h96, 1'b0));
        repeat (4) @(negedge clk);
    endtask

    task automatic t_break();
        check("R9 enabled drives oe", txd_oe, 1);
        port_dir = 1; port_dat = 0;
        wr(1, 8'h00);
        #1;
        check("R9 break level from port", {txd, txd_oe}, 2'b01);
        check("R8 txi low when disabled", txi, 0);
        port_dir = 0; port_dat = 1; #1;
        check("R9 port released", {txd, txd_oe}, 2'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        wr(3, 8'd3);
        wr(1, 8'h01);
        t_frame(8'hA5, 1'b1);
        t_frame(8'h5A, 1'b0);
        t_period();
        t_back_to_back();
        t_ignored();
        t_dma();
        t_break();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule